// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Serial Link

This block moves a stream of single bits from a sender to a receiver over a three-wire channel. Two wires carry the code word: a value rail and a redundant rail. The third wire carries acknowledge back from the receiver. Each bit is sent as a fresh code word in the opposite phase from the one before it. The phase is the XOR of the two rails. No idle or spacer word is sent between bits, and the receiver spots a new bit only by a change in that XOR.

The transmitter accepts bits on a valid/ready input. It drives both rails from registers in the same cycle, then waits until the acknowledge level matches the phase it last sent. The receiver watches the rails for a phase change and holds the decoded bit on a valid/ready output. It moves acknowledge to the new phase only once that bit has been taken. Both ends share one clock.

The parameter `CHAN_DLY` inserts a number of register stages on both the forward rails and the returned acknowledge. These stages model wire flight time. The two rails always travel in the same stage, so the receiver never sees half of a code word.

Transmitter states: `TX_IDLE` (ready for a bit) and `TX_WAIT` (a word is on the rails and not yet acknowledged).
- `TX_IDLE` goes to `TX_WAIT` when a bit is accepted.
- `TX_WAIT` goes to `TX_IDLE` when the acknowledge level seen equals the last sent phase.

Receiver states: `RX_LISTEN` (no bit held) and `RX_HOLD` (bit presented).
- `RX_LISTEN` goes to `RX_HOLD` when the rail phase differs from the acknowledge level.
- `RX_HOLD` goes to `RX_LISTEN` on an output handshake.

Top module: `ledr_link`

## Requirements
- R1: After reset both rails are 0, acknowledge is 0, out_valid is 0 and in_ready is 1. Phase 0 counts as already consumed, so the first bit goes out in phase 1.
- R2: For a bit sent in phase p, the value rail equals the bit and the redundant rail equals bit XOR p. So phase 0 gives 00 for a 0 and 11 for a 1, and phase 1 gives 01 for a 0 and 10 for a 1 (written as value, redundant).
- R3: The phase (value XOR redundant) flips on every accepted bit, with no spacer word between bits.
- R4: Each newly accepted bit changes exactly one of the two rails.
- R5: The receiver raises out_valid, with out_bit equal to the value rail, exactly CHAN_DLY+1 cycles after the rails change. It raises nothing while the rail phase equals the acknowledge level.
- R6: Acknowledge equals the phase of the last bit taken at the output. It changes in the cycle of the out_valid/out_ready handshake and at no other time.
- R7: in_ready returns to 1 exactly CHAN_DLY+1 cycles after the output handshake. It stays 0 from the accepting edge until then.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_bit and acknowledge all hold.
- R9: While the transmitter waits, the rails hold their code word even if in_valid and in_bit change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sender offers a bit |
| in_bit | input | 1 | Bit offered |
| in_ready | output | 1 | Transmitter can take a bit |
| out_valid | output | 1 | Receiver presents a bit |
| out_bit | output | 1 | Decoded bit |
| out_ready | input | 1 | Consumer takes the bit |
| rail_v | output | 1 | Value rail as driven by the transmitter |
| rail_r | output | 1 | Redundant rail as driven by the transmitter |
| ack | output | 1 | Acknowledge level as driven by the receiver |

## Verification
Take an accepting edge k. The rails are due right after edge k. out_valid is due after edge k+CHAN_DLY+1. Acknowledge moves right after the handshake edge h, and in_ready rises after edge h+CHAN_DLY+1. The bench samples on the falling edge. It counts edges from each event and checks both the cycle before each result is due, when the old value must still be present, and the cycle it is due. During a stall it checks every cycle that the output, acknowledge and rails stay unchanged.

// File: rtl/ledr_pkg.sv
package ledr_pkg;
    typedef enum logic {TX_IDLE = 1'b0, TX_WAIT = 1'b1} tx_state_t;
    typedef enum logic {RX_LISTEN = 1'b0, RX_HOLD = 1'b1} rx_state_t;
endpackage

// File: rtl/ledr_delay.sv
module ledr_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stage_q [DEPTH];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/ledr_tx.sv
module ledr_tx
    import ledr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    input  logic ack_seen,
    output logic rail_v,
    output logic rail_r
);
    tx_state_t state_q, state_d;
    logic      phase_q;
    logic      take;

    assign in_ready = (state_q == TX_IDLE);
    assign take     = in_ready && in_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (in_valid) state_d = TX_WAIT;
            TX_WAIT: if (ack_seen == phase_q) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            rail_v  <= 1'b0;
            rail_r  <= 1'b0;
        end else if (take) begin
            phase_q <= ~phase_q;
            rail_v  <= in_bit;
            rail_r  <= in_bit ^ ~phase_q;
        end
    end

    a_r2_value_rail: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rail_v == $past(in_bit));
    a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (rail_v ^ rail_r) != $past(rail_v ^ rail_r));
    a_r4_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> $countones({rail_v, rail_r} ^ $past({rail_v, rail_r})) == 1);
    a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_WAIT) |=> $stable({rail_v, rail_r}));
    a_r7_ack_matches: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ack_seen == (rail_v ^ rail_r));
endmodule

// File: rtl/ledr_rx.sv
module ledr_rx
    import ledr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rv_seen,
    input  logic rr_seen,
    output logic out_valid,
    output logic out_bit,
    input  logic out_ready,
    output logic ack
);
    rx_state_t state_q, state_d;
    logic      fresh;

    assign out_valid = (state_q == RX_HOLD);
    assign fresh     = (rv_seen ^ rr_seen) != ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_LISTEN: if (fresh) state_d = RX_HOLD;
            RX_HOLD:   if (out_ready) state_d = RX_LISTEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_LISTEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit <= 1'b0;
            ack     <= 1'b0;
        end else begin
            if (state_q == RX_LISTEN && fresh) out_bit <= rv_seen;
            if (state_q == RX_HOLD && out_ready) ack <= ~ack;
        end
    end

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_bit) && $stable(ack));
    a_r6_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> ack != $past(ack));
    a_r6_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready) |=> $stable(ack));
    a_r5_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && (rv_seen ^ rr_seen) == ack) |=> !out_valid);
endmodule

// File: rtl/ledr_link.sv
module ledr_link #(
    parameter int CHAN_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    input  logic out_ready,
    output logic rail_v,
    output logic rail_r,
    output logic ack
);
    logic [1:0] rails_far;
    logic       ack_far;

    ledr_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .in_ready (in_ready),
        .ack_seen (ack_far),
        .rail_v   (rail_v),
        .rail_r   (rail_r)
    );

    ledr_delay #(.W(2), .DEPTH(CHAN_DLY)) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rail_v, rail_r}),
        .q     (rails_far)
    );

    ledr_delay #(.W(1), .DEPTH(CHAN_DLY)) u_back (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack),
        .q     (ack_far)
    );

    ledr_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rv_seen   (rails_far[1]),
        .rr_seen   (rails_far[0]),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_ready (out_ready),
        .ack       (ack)
    );

    a_r1_reset_rest: assert property (@(posedge clk)
        !rst_n |=> !rail_v && !rail_r && !ack && !out_valid && in_ready);
endmodule

// File: tb/tb_ledr_link.sv
module tb_ledr_link;
    localparam int D = 1;

    typedef struct packed {
        logic       b;
        logic [2:0] stall;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b1, 3'd0}, '{1'b1, 3'd2}, '{1'b0, 3'd0}, '{1'b0, 3'd1},
        '{1'b1, 3'd3}, '{1'b0, 3'd0}, '{1'b1, 3'd0}, '{1'b1, 3'd5},
        '{1'b1, 3'd0}, '{1'b0, 3'd2}, '{1'b0, 3'd0}, '{1'b1, 3'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_bit, rail_v, rail_r, ack;
    int   n_chk = 0, n_bad = 0;
    logic ph;
    logic [1:0] prev_rails;

    always #2.5 clk = ~clk;

    ledr_link #(.CHAN_DLY(D)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
        .out_ready(out_ready), .rail_v(rail_v), .rail_r(rail_r), .ack(ack)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({rail_v, rail_r} == 2'b00, "R1 rails", {rail_v, rail_r}, 0);
        chk(ack == 1'b0, "R1 ack", ack, 0);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        ph = 1'b0;
        prev_rails = 2'b00;

        for (int i = 0; i < 12; i++) begin
            logic prev_ack;
            prev_ack = ph;
            ph = ~ph;
            in_valid = 1'b1;
            in_bit = VEC[i].b;
            @(negedge clk);
            // R2 encoding, R3 phase alternation, R4 one rail toggles
            chk(rail_v == VEC[i].b, "R2 value rail", rail_v, VEC[i].b);
            chk(rail_r == (VEC[i].b ^ ph), "R2 redundant rail", rail_r, VEC[i].b ^ ph);
            chk((rail_v ^ rail_r) == ph, "R3 phase", rail_v ^ rail_r, ph);
            chk($countones({rail_v, rail_r} ^ prev_rails) == 1, "R4 one toggle",
                $countones({rail_v, rail_r} ^ prev_rails), 1);
            chk(in_ready == 1'b0, "R7 busy", in_ready, 0);
            prev_rails = {rail_v, rail_r};
            in_bit = ~VEC[i].b;               // R9 junk while waiting
            repeat (D) @(negedge clk);
            chk(out_valid == 1'b0, "R5 not early", out_valid, 0);
            @(negedge clk);
            chk(out_valid == 1'b1, "R5 valid due", out_valid, 1);
            chk(out_bit == VEC[i].b, "R5 out_bit", out_bit, VEC[i].b);
            chk(ack == prev_ack, "R6 ack before take", ack, prev_ack);
            for (int s = 0; s < VEC[i].stall; s++) begin
                @(negedge clk);
                chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
                chk(out_bit == VEC[i].b, "R8 bit held", out_bit, VEC[i].b);
                chk(ack == prev_ack, "R8 ack held", ack, prev_ack);
                chk({rail_v, rail_r} == prev_rails, "R9 rails held", {rail_v, rail_r}, prev_rails);
                chk(in_ready == 1'b0, "R7 busy stall", in_ready, 0);
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            chk(ack == ph, "R6 ack level", ack, ph);
            chk(out_valid == 1'b0, "R6 valid drops", out_valid, 0);
            chk({rail_v, rail_r} == prev_rails, "R9 rails held", {rail_v, rail_r}, prev_rails);
            repeat (D) @(negedge clk);
            chk(in_ready == 1'b0, "R7 not early", in_ready, 0);
            if (i == 11) in_valid = 1'b0;
            @(negedge clk);
            chk(in_ready == 1'b1, "R7 ready due", in_ready, 1);
        end

        // R5: no new word on the rails, consumer ready: nothing appears
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R5 no phantom", out_valid, 0);
            chk(ack == ph, "R6 ack quiet", ack, ph);
        end
        out_ready = 1'b0;

        // R1 again: reset mid-run returns to rest
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rail_v, rail_r, ack} == 3'b000, "R1 re-reset", {rail_v, rail_r, ack}, 0);
        chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
        finish_run();
    end
endmodule